// File: doc/BRIEF.md
# Multi-Line Memory Write Issuer

This block sits between a command source and an outbound memory write channel. A command names a cache-line address, a length of one, two or four lines, a write type, a virtual channel and a 16-bit tag. The block checks the command, then emits one 80-bit header and one 512-bit data word per beat, taking one data word from an inbound data stream for each beat. A fence command produces a single header-only beat and takes no data.

The command port is a valid/ready handshake, and `cmd_ready` is high only when no payload is in flight. The data stream is also valid/ready. `dat_ready` is high only when the block is in the middle of a data write and the outbound budget allows a beat. A data word moves on the edge where both `dat_valid` and `dat_ready` are high. The data source may leave gaps of any length between words. The outbound side has no ready signal. Instead, the sink raises `tx_almfull`, and from the first cycle it is high the block sends no more than a fixed number of further beats. That number is refreshed only when `tx_almfull` falls. A rejected command is accepted and dropped: it raises `cmd_err` for one cycle and sends nothing.

Top module: `mline_wr_issuer`

## Requirements
- R1: After reset, `tx_valid` and `cmd_err` are 0 and `cmd_ready` is 1.
- R2: The length code sets the beat count: 2'b00 gives 1 beat, 2'b01 gives 2 beats and 2'b11 gives 4 beats. Code 2'b10 is rejected.
- R3: A data write whose address is not naturally aligned is rejected. For 2 lines that means address bit 0 set; for 4 lines it means address bits [1:0] not 00. A rejected command raises `cmd_err` for exactly one cycle, in the cycle after it is accepted, and produces no beat.
- R4: The first beat of a command has sop=1 and the full base address. Later beats have sop=0 and address base+k (k = 1, 2, 3), so the beats go out lowest address first.
- R5: Header layout: channel at [73:72], sop at [71], length code at [69:68], type at [67:64], line address at [57:16] and tag at [15:0]. Bits [79:74], [70] and [63:58] are 0.
- R6: `cmd_ready` is 0 from the cycle after a good command is accepted until its last beat has been issued, so no command starts before the current payload ends.
- R7: While `tx_almfull` is 1, at most 8 beats are issued, counting from the first cycle it is 1. A payload already started stalls at that limit and resumes after `tx_almfull` returns to 0.
- R8: A fence (type 4) issues one beat with sop=1, length 0, address 0 and data 0. It keeps the channel and the tag, consumes no data word and needs no alignment.
- R9: Types other than 0 (write without caching), 1 (write with modified hint) and 2 (push to host cache) or 4 (fence) are rejected like R3. This includes type 6 (interrupt).
- R10: A data beat moves only on a `dat_valid` and `dat_ready` handshake, and `tx_data` carries the word taken in that handshake. `dat_ready` is 0 when idle, during a fence, and when the budget is spent.
- R11: A beat appears on `tx_valid`/`tx_hdr`/`tx_data` exactly one cycle after the edge on which it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this edge |
| cmd_addr | input | 42 | Cache-line address |
| cmd_len | input | 2 | Length code (00=1, 01=2, 11=4 lines) |
| cmd_type | input | 4 | Write type (0, 1, 2, 4 accepted) |
| cmd_vc | input | 2 | Virtual channel select |
| cmd_tag | input | 16 | Tag copied into every header |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word taken this edge |
| dat_data | input | 512 | Data word |
| tx_valid | output | 1 | Outbound beat valid |
| tx_hdr | output | 80 | Outbound header |
| tx_data | output | 512 | Outbound data |
| tx_almfull | input | 1 | Outbound channel almost full |

## Verification
The hardest case to reach is `tx_almfull` rising while a four-line payload is partly sent, with the budget running out between two beats of the same command. The stimulus holds `tx_almfull` high and first spends seven units of budget on single-line writes. A four-line write then gets exactly one beat out before it stalls, and the bench checks the stall before releasing `tx_almfull`. A cycle-level reference model tracks the budget and the payload position, so every stalled and every resumed beat is compared on each clock. Data words arrive with gaps, so beats inside one command are spread out in time.

// File: rtl/mwi_pkg.sv
package mwi_pkg;
  localparam int LINE_AW = 42;
  localparam int TAG_W   = 16;
  localparam int HDR_W   = 80;

  localparam logic [3:0] WT_PLAIN = 4'd0;
  localparam logic [3:0] WT_MOD   = 4'd1;
  localparam logic [3:0] WT_PUSH  = 4'd2;
  localparam logic [3:0] WT_FENCE = 4'd4;

  localparam logic [1:0] LEN_ONE  = 2'b00;
  localparam logic [1:0] LEN_TWO  = 2'b01;
  localparam logic [1:0] LEN_FOUR = 2'b11;

  typedef struct packed {
    logic [1:0]         vc;
    logic               sop;
    logic [1:0]         len;
    logic [3:0]         wtype;
    logic [LINE_AW-1:0] addr;
    logic [TAG_W-1:0]   tag;
  } beat_fields_t;

  function automatic logic [HDR_W-1:0] pack_hdr(input beat_fields_t f);
    logic [HDR_W-1:0] h;
    h          = '0;
    h[73:72]   = f.vc;
    h[71]      = f.sop;
    h[69:68]   = f.len;
    h[67:64]   = f.wtype;
    h[57:16]   = f.addr;
    h[15:0]    = f.tag;
    return h;
  endfunction
endpackage

// File: rtl/mwi_cmd_check.sv
module mwi_cmd_check
  import mwi_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] len,
  input  logic [3:0] wtype,
  output logic       ok,
  output logic       fence,
  output logic [2:0] beats
);
  logic is_data;
  logic align_ok;

  always_comb begin
    is_data = (wtype == WT_PLAIN) || (wtype == WT_MOD) || (wtype == WT_PUSH);
    fence   = (wtype == WT_FENCE);
    unique case (len)
      LEN_ONE:  begin align_ok = 1'b1;              beats = 3'd1; end
      LEN_TWO:  begin align_ok = !addr_lo[0];       beats = 3'd2; end
      LEN_FOUR: begin align_ok = (addr_lo == 2'b00); beats = 3'd4; end
      default:  begin align_ok = 1'b0;              beats = 3'd1; end
    endcase
    if (fence) beats = 3'd1;
    ok = fence || (is_data && align_ok);
  end
endmodule

// File: rtl/mwi_budget.sv
module mwi_budget #(
  parameter int BUDGET = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic almfull,
  input  logic issue,
  output logic can_send
);
  localparam int CW = $clog2(BUDGET + 2);

  logic [CW-1:0] credit;

  assign can_send = !almfull || (credit != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        credit <= CW'(BUDGET);
    else if (!almfull) credit <= CW'(BUDGET);
    else if (issue)    credit <= credit - 1'b1;
  end

  // independent tally of beats sent while almost-full is held
  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n)        seen <= '0;
    else if (!almfull) seen <= '0;
    else if (issue)    seen <= seen + 1'b1;
  end

  assert_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= CW'(BUDGET));
endmodule

// File: rtl/mwi_beat_seq.sv
module mwi_beat_seq
  import mwi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [LINE_AW-1:0] cmd_addr,
  input  logic [1:0]         cmd_len,
  input  logic [3:0]         cmd_type,
  input  logic [1:0]         cmd_vc,
  input  logic [TAG_W-1:0]   cmd_tag,
  input  logic               chk_ok,
  input  logic               chk_fence,
  input  logic [2:0]         chk_beats,
  input  logic               dat_valid,
  input  logic               can_send,
  output logic               cmd_ready,
  output logic               dat_ready,
  output logic               issue,
  output logic               beat_fence,
  output beat_fields_t       beat,
  output logic               cmd_err
);
  logic               busy;
  logic               fence_q;
  logic [LINE_AW-1:0] base_q;
  logic [1:0]         len_q;
  logic [3:0]         type_q;
  logic [1:0]         vc_q;
  logic [TAG_W-1:0]   tag_q;
  logic [2:0]         nbeats_q;
  logic [2:0]         idx_q;
  logic               cmd_fire;
  logic               last;

  assign cmd_ready  = !busy;
  assign cmd_fire   = cmd_valid && !busy;
  assign dat_ready  = busy && !fence_q && can_send;
  assign issue      = busy && can_send && (fence_q || dat_valid);
  assign last       = (idx_q == nbeats_q - 3'd1);
  assign beat_fence = fence_q;

  always_comb begin
    beat.vc    = vc_q;
    beat.sop   = (idx_q == 3'd0);
    beat.len   = len_q;
    beat.wtype = type_q;
    beat.addr  = {base_q[LINE_AW-1:2], base_q[1:0] | idx_q[1:0]};
    beat.tag   = tag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      fence_q  <= 1'b0;
      base_q   <= '0;
      len_q    <= '0;
      type_q   <= '0;
      vc_q     <= '0;
      tag_q    <= '0;
      nbeats_q <= 3'd1;
      idx_q    <= '0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_err <= cmd_fire && !chk_ok;
      if (cmd_fire && chk_ok) begin
        busy     <= 1'b1;
        fence_q  <= chk_fence;
        base_q   <= chk_fence ? '0 : cmd_addr;
        len_q    <= chk_fence ? LEN_ONE : cmd_len;
        type_q   <= cmd_type;
        vc_q     <= cmd_vc;
        tag_q    <= cmd_tag;
        nbeats_q <= chk_beats;
        idx_q    <= '0;
      end else if (issue) begin
        if (last) begin
          busy  <= 1'b0;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + 3'd1;
        end
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && chk_ok) |=> !cmd_ready);

  assert_fence_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && chk_fence && chk_ok) |=> !dat_ready);
endmodule

// File: rtl/mline_wr_issuer.sv
module mline_wr_issuer
  import mwi_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int BUDGET = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [LINE_AW-1:0] cmd_addr,
  input  logic [1:0]         cmd_len,
  input  logic [3:0]         cmd_type,
  input  logic [1:0]         cmd_vc,
  input  logic [TAG_W-1:0]   cmd_tag,
  output logic               cmd_err,
  input  logic               dat_valid,
  output logic               dat_ready,
  input  logic [DATA_W-1:0]  dat_data,
  output logic               tx_valid,
  output logic [HDR_W-1:0]   tx_hdr,
  output logic [DATA_W-1:0]  tx_data,
  input  logic               tx_almfull
);
  logic         chk_ok;
  logic         chk_fence;
  logic [2:0]   chk_beats;
  logic         can_send;
  logic         issue;
  logic         beat_fence;
  beat_fields_t beat;

  mwi_cmd_check u_check (
    .addr_lo (cmd_addr[1:0]),
    .len     (cmd_len),
    .wtype   (cmd_type),
    .ok      (chk_ok),
    .fence   (chk_fence),
    .beats   (chk_beats)
  );

  mwi_budget #(.BUDGET(BUDGET)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .almfull  (tx_almfull),
    .issue    (issue),
    .can_send (can_send)
  );

  mwi_beat_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .cmd_type   (cmd_type),
    .cmd_vc     (cmd_vc),
    .cmd_tag    (cmd_tag),
    .chk_ok     (chk_ok),
    .chk_fence  (chk_fence),
    .chk_beats  (chk_beats),
    .dat_valid  (dat_valid),
    .can_send   (can_send),
    .cmd_ready  (cmd_ready),
    .dat_ready  (dat_ready),
    .issue      (issue),
    .beat_fence (beat_fence),
    .beat       (beat),
    .cmd_err    (cmd_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_hdr   <= '0;
      tx_data  <= '0;
    end else begin
      tx_valid <= issue;
      if (issue) begin
        tx_hdr  <= pack_hdr(beat);
        tx_data <= beat_fence ? '0 : dat_data;
      end
    end
  end

  assert_later_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_hdr[71]) |-> (tx_hdr[17:16] != 2'b00));

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_hdr[79:74] == '0 && !tx_hdr[70] && tx_hdr[63:58] == '0));

  assert_fence_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_hdr[67:64] == WT_FENCE) |-> (tx_data == '0 && tx_hdr[57:16] == '0));

  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !tx_valid);
endmodule

// File: tb/tb_mline_wr_issuer.sv
module tb_mline_wr_issuer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [41:0]  cmd_addr = '0;
  logic [1:0]   cmd_len = '0;
  logic [3:0]   cmd_type = '0;
  logic [1:0]   cmd_vc = '0;
  logic [15:0]  cmd_tag = '0;
  logic         cmd_err;
  logic         dat_valid = 1'b0;
  logic         dat_ready;
  logic [511:0] dat_data = '0;
  logic         tx_valid;
  logic [79:0]  tx_hdr;
  logic [511:0] tx_data;
  logic         tx_almfull = 1'b0;

  mline_wr_issuer dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // data source: a fresh word every cycle, optional gaps
  int cyc = 0;
  int gap_mode = 0;
  always @(negedge clk) begin
    cyc++;
    dat_valid <= (gap_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    dat_data  <= {16{cyc[31:0]}};
  end

  // behavioural reference model
  bit          m_busy, m_fence;
  logic [41:0] m_base;
  int          m_n, m_idx, m_cred;
  logic [1:0]  m_len, m_vc;
  logic [3:0]  m_type;
  logic [15:0] m_tag;
  bit          e_valid, e_err;
  logic [79:0] e_hdr;
  logic [511:0] e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_fence = 0; m_cred = 8; m_idx = 0; m_n = 1;
      e_valid = 0; e_err = 0; e_hdr = '0; e_data = '0;
    end else begin
      bit can, iss, was_busy, good;
      was_busy = m_busy;
      can = !tx_almfull || (m_cred > 0);
      iss = m_busy && can && (m_fence || dat_valid);
      e_valid = iss;
      e_err = 0;
      if (iss) begin
        e_hdr = '0;
        e_hdr[73:72] = m_vc;
        e_hdr[71]    = (m_idx == 0);
        e_hdr[69:68] = m_fence ? 2'b00 : m_len;
        e_hdr[67:64] = m_type;
        e_hdr[57:16] = m_fence ? 42'd0 : m_base + 42'(m_idx);
        e_hdr[15:0]  = m_tag;
        e_data = m_fence ? '0 : dat_data;
      end
      if (!tx_almfull) m_cred = 8;
      else if (iss) m_cred--;
      if (iss) begin
        m_idx++;
        if (m_fence || m_idx == m_n) begin m_busy = 0; m_idx = 0; end
      end
      if (!was_busy && cmd_valid) begin
        good = 0;
        if (cmd_type == 4) begin good = 1; m_n = 1; end
        else if (cmd_type <= 2) begin
          case (cmd_len)
            2'b00: begin good = 1; m_n = 1; end
            2'b01: begin good = (cmd_addr[0] == 0); m_n = 2; end
            2'b11: begin good = (cmd_addr[1:0] == 0); m_n = 4; end
            default: good = 0;
          endcase
        end
        if (good) begin
          m_busy = 1; m_fence = (cmd_type == 4); m_idx = 0;
          m_base = cmd_addr; m_len = cmd_len; m_type = cmd_type;
          m_vc = cmd_vc; m_tag = cmd_tag;
        end else e_err = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  int bc = 0, ec = 0;
  logic [79:0] hq[$];
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(tx_valid == e_valid, "R11 tx_valid", 512'(tx_valid), 512'(e_valid));
      if (e_valid && tx_valid) begin
        chk(tx_hdr == e_hdr, "R4/R5 header", 512'(tx_hdr), 512'(e_hdr));
        chk(tx_data == e_data, "R10 data", tx_data, e_data);
      end
      chk(cmd_err == e_err, "R3/R9 cmd_err", 512'(cmd_err), 512'(e_err));
      chk(cmd_ready == !m_busy, "R6 cmd_ready", 512'(cmd_ready), 512'(!m_busy));
      chk(dat_ready == (m_busy && !m_fence && (!tx_almfull || m_cred > 0)),
          "R7/R10 dat_ready", 512'(dat_ready),
          512'(m_busy && !m_fence && (!tx_almfull || m_cred > 0)));
      if (tx_valid) begin bc++; hq.push_back(tx_hdr); end
      if (cmd_err) ec++;
    end
  end

  task automatic send(input logic [41:0] a, input logic [1:0] l, input logic [3:0] t,
                      input logic [1:0] v, input logic [15:0] g);
    @(negedge clk);
    cmd_valid = 1; cmd_addr = a; cmd_len = l; cmd_type = t; cmd_vc = v; cmd_tag = g;
    #1;
    for (int i = 0; i < 500 && !cmd_ready; i++) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #3;
      if (cmd_ready && !tx_valid) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk(cmd_ready == 1 && tx_valid == 0 && cmd_err == 0, "R1 reset state",
        512'({cmd_ready, tx_valid, cmd_err}), 512'(3'b100));
    @(negedge clk); rst_n = 1;
    #3;
    chk(cmd_ready == 1 && tx_valid == 0, "R1 after release",
        512'({cmd_ready, tx_valid}), 512'(2'b10));

    // R2: single line
    bc = 0; send(42'h123, 2'b00, 4'd0, 2'd1, 16'hA001); wait_idle();
    chk(bc == 1, "R2 one line", 512'(bc), 512'(1));

    // R2: two lines, gaps in data (R10)
    gap_mode = 1;
    bc = 0; send(42'h3FF_0000_0002, 2'b01, 4'd1, 2'd2, 16'hB002); wait_idle();
    chk(bc == 2, "R2 two lines", 512'(bc), 512'(2));

    // R4: four lines, ordering and sop
    bc = 0; hq.delete(); send(42'h0AB_CDE0_0004, 2'b11, 4'd2, 2'd3, 16'hC003); wait_idle();
    chk(bc == 4, "R2 four lines", 512'(bc), 512'(4));
    if (hq.size() == 4) begin
      chk(hq[0][71] == 1 && hq[1][71] == 0 && hq[3][71] == 0, "R4 sop only first",
          512'({hq[0][71], hq[1][71], hq[3][71]}), 512'(3'b100));
      chk(hq[3][17:16] == 2'd3 && hq[1][17:16] == 2'd1, "R4 ascending offsets",
          512'({hq[1][17:16], hq[3][17:16]}), 512'(4'b0111));
    end
    gap_mode = 0;

    // R3: misalignment, R9: bad types, R2: bad length code
    bc = 0; ec = 0;
    send(42'h5, 2'b01, 4'd0, 2'd0, 16'h1); wait_idle();
    send(42'h6, 2'b11, 4'd1, 2'd0, 16'h2); wait_idle();
    chk(bc == 0 && ec == 2, "R3 misaligned rejected", 512'({bc, ec}), 512'({32'd0, 32'd2}));
    send(42'h8, 2'b10, 4'd0, 2'd0, 16'h3); wait_idle();
    chk(ec == 3 && bc == 0, "R2 length code 10 rejected", 512'(ec), 512'(3));
    send(42'h8, 2'b00, 4'd6, 2'd0, 16'h4); wait_idle();
    send(42'h8, 2'b00, 4'd3, 2'd0, 16'h5); wait_idle();
    chk(ec == 5 && bc == 0, "R9 unsupported type rejected", 512'(ec), 512'(5));

    // R8: fence with junk address and length
    bc = 0; hq.delete(); send(42'h7, 2'b11, 4'd4, 2'd2, 16'hFE0C); wait_idle();
    chk(bc == 1, "R8 fence single beat", 512'(bc), 512'(1));
    if (hq.size() == 1)
      chk(hq[0][57:16] == 0 && hq[0][69:68] == 0 && hq[0][15:0] == 16'hFE0C,
          "R8 fence header", 512'(hq[0]), 512'(80'h0));

    // R6: back-to-back commands
    bc = 0;
    send(42'h100, 2'b11, 4'd0, 2'd0, 16'h0101);
    send(42'h200, 2'b01, 4'd0, 2'd0, 16'h0202);
    wait_idle();
    chk(bc == 6, "R6 back-to-back beats", 512'(bc), 512'(6));

    // R7: budget with almfull held across whole commands
    @(negedge clk); tx_almfull = 1;
    bc = 0;
    send(42'h300, 2'b11, 4'd0, 2'd1, 16'h0301);
    send(42'h304, 2'b11, 4'd0, 2'd1, 16'h0302);
    send(42'h308, 2'b11, 4'd0, 2'd1, 16'h0303);
    repeat (20) @(negedge clk);
    chk(bc == 8, "R7 stops after budget", 512'(bc), 512'(8));
    tx_almfull = 0; wait_idle();
    chk(bc == 12, "R7 resumes after release", 512'(bc), 512'(12));

    // R7: budget spent mid-payload
    @(negedge clk); tx_almfull = 1;
    bc = 0;
    for (int k = 0; k < 7; k++) send(42'h400 + 42'(k), 2'b00, 4'd1, 2'd0, 16'(k));
    send(42'h500, 2'b11, 4'd2, 2'd3, 16'h0500);
    repeat (20) @(negedge clk);
    chk(bc == 8, "R7 mid-payload stall", 512'(bc), 512'(8));
    tx_almfull = 0; wait_idle();
    chk(bc == 11, "R7 mid-payload completes", 512'(bc), 512'(11));

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule